// File: doc/BRIEF.md
# Symbol-Pair Line State Detector

This block classifies the state of a serial ring link from a stream of already-decoded 5-bit line symbols. Two symbols arrive on every byte clock. The block pairs them, sorts each pair into a class, and counts runs of identical or alternating classes. From those runs it declares one of six line states: Quiet, Halt, Master, Idle, Super Idle or Active. The live state is offered as a 3-bit code. A one-cycle pulse marks each change of state, and a sticky history keeps one bit per state that the host clears bit by bit.

Pair alignment is found from the start-of-frame delimiter, the J symbol followed by the K symbol. When that pattern shows up straddling two input words, the pairing shifts by one symbol. A hold input freezes the pairing. A J-K pair that arrives while the line is already Active is reported as a frame start. When the line is in any other state, the same pair moves the line into Active instead.

Top module: `line_state_detector`

## Requirements
- R1: A run of IDLE_RUN (default 4) consecutive Idle pairs (11111 11111) sets `ls_code` to Idle (4). Seven consecutive Idle pairs still give Idle.
- R2: A run of SUPER_RUN (default 8) consecutive Idle pairs sets `ls_code` to Super Idle (5). A ninth Idle pair keeps it at Super Idle.
- R3: A run of QUIET_RUN consecutive Quiet pairs (00000 00000) gives Quiet (1). A run of HALT_RUN consecutive Halt pairs (00100 00100) gives Halt (2). Both thresholds default to 4.
- R4: A run of MASTER_RUN (default 4) pairs that alternate strictly between Halt and Quiet gives Master (3).
- R5: Any pair that breaks a run restarts that run's count. A pair that completes no run leaves `ls_code` unchanged. After reset the code is 0, meaning no state is known yet.
- R6: A J-K pair (11000 10001) moves a line that is not Active into Active (6), with `frame_start` low. A J-K pair received while the line is already Active pulses `frame_start` high for one cycle and leaves the state unchanged.
- R7: Every new state pulses `ls_change` for one cycle, in the same cycle that `ls_code` updates. It also sets `ls_hist` bit (code-1): bit 0 Quiet, bit 1 Halt, bit 2 Master, bit 3 Idle, bit 4 Super Idle, bit 5 Active.
- R8: An `ls_hist` bit stays set until a `hist_clr` pulse on that same bit. If a set and a clear fall on the same cycle, the set wins.
- R9: When `frame_hold` is low and the pattern J then K appears as the low symbol of one word followed by the high symbol of the next word, the pairing flips. `align_phase` becomes 1, that J-K is classified, and later pairs are formed as {previous `sym_lo`, current `sym_hi`}.
- R10: While `frame_hold` is high, `align_phase` does not change. A straddling J-K is then not treated as a J-K pair.
- R11: A synchronous reset clears `ls_code`, `ls_hist`, `ls_change`, `frame_start` and `align_phase` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, one symbol pair per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sym_hi | input | 5 | First decoded symbol of the word |
| sym_lo | input | 5 | Second decoded symbol of the word |
| frame_hold | input | 1 | Freezes the current pair alignment |
| hist_clr | input | 6 | Per-bit clear pulses for the history |
| ls_code | output | 3 | Current line state code |
| ls_change | output | 1 | One-cycle pulse when the state changes |
| frame_start | output | 1 | J-K received while already Active |
| align_phase | output | 1 | 0 = pair is {sym_hi, sym_lo}; 1 = pair is {previous sym_lo, sym_hi} |
| ls_hist | output | 6 | Sticky record of states entered |

## Verification
The run counters are internal, so a counter that miscounts shows at the ports as a state code that updates one pair too early or one pair too late. For that reason the bench compares `ls_code` after every single pair, and it exercises the 7-, 8- and 9-pair Idle runs exactly. A wrong alignment phase shows up one pair after the straddling J-K, and it stays visible in every Idle count that follows. A history bit that is set wrongly, or cleared wrongly, stays wrong until the next clear, so the bench reads `ls_hist` on every cycle.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    localparam int SYM_W  = 5;
    localparam int NUM_LS = 6;

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        sym_t first;
        sym_t second;
    } pair_t;

    localparam sym_t SYM_IDLE  = 5'b11111;
    localparam sym_t SYM_J     = 5'b11000;
    localparam sym_t SYM_K     = 5'b10001;
    localparam sym_t SYM_QUIET = 5'b00000;
    localparam sym_t SYM_HALT  = 5'b00100;

    typedef enum logic [2:0] {
        LS_NONE   = 3'd0,
        LS_QUIET  = 3'd1,
        LS_HALT   = 3'd2,
        LS_MASTER = 3'd3,
        LS_IDLE   = 3'd4,
        LS_SUPER  = 3'd5,
        LS_ACTIVE = 3'd6
    } lstate_e;

    typedef enum logic [2:0] {
        PC_OTHER,
        PC_IDLE,
        PC_QUIET,
        PC_HALT,
        PC_JK
    } pclass_e;

    function automatic logic is_jk(pair_t p);
        return (p.first == SYM_J) && (p.second == SYM_K);
    endfunction

    function automatic pclass_e classify(pair_t p);
        if (is_jk(p))                                         return PC_JK;
        if ((p.first == SYM_IDLE)  && (p.second == SYM_IDLE))  return PC_IDLE;
        if ((p.first == SYM_QUIET) && (p.second == SYM_QUIET)) return PC_QUIET;
        if ((p.first == SYM_HALT)  && (p.second == SYM_HALT))  return PC_HALT;
        return PC_OTHER;
    endfunction

endpackage

// File: rtl/lsd_aligner.sv
module lsd_aligner
    import lsd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sym_t  sym_hi,
    input  sym_t  sym_lo,
    input  logic  hold,
    output pair_t pair,
    output logic  phase
);

    sym_t  prev_lo;
    logic  phase_q;
    pair_t pair_even;
    pair_t pair_odd;
    pair_t pair_alt;
    logic  flip;
    logic  phase_eff;

    always_comb begin
        pair_even = '{first: sym_hi,  second: sym_lo};
        pair_odd  = '{first: prev_lo, second: sym_hi};
        pair_alt  = phase_q ? pair_even : pair_odd;
        flip      = !hold && is_jk(pair_alt);
        phase_eff = phase_q ^ flip;
        pair      = phase_eff ? pair_odd : pair_even;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lo <= '0;
            phase_q <= 1'b0;
        end else begin
            prev_lo <= sym_lo;
            phase_q <= phase_eff;
        end
    end

    assign phase = phase_q;

    // R10: alignment is frozen while hold is asserted
    assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hold)) |-> $stable(phase_q));

endmodule

// File: rtl/lsd_run_ctr.sv
module lsd_run_ctr #(
    parameter int LIMIT = 8,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cont,
    input  logic         start,
    output logic [W-1:0] cnt_next,
    output logic [W-1:0] cnt_q
);

    localparam logic [W-1:0] LIM = W'(LIMIT);

    always_comb begin
        if (cont)
            cnt_next = (cnt_q >= LIM) ? LIM : cnt_q + 1'b1;
        else if (start)
            cnt_next = W'(1);
        else
            cnt_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_next;
    end

    // R5: the count never exceeds its limit
    assert_ctr_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM);

    // R5: a pair that neither continues nor starts a run restarts the count
    assert_run_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cont) && !$past(start)) |-> (cnt_q == '0));

endmodule

// File: rtl/lsd_fsm.sv
module lsd_fsm
    import lsd_pkg::*;
#(
    parameter int IDLE_RUN   = 4,
    parameter int SUPER_RUN  = 8,
    parameter int QUIET_RUN  = 4,
    parameter int HALT_RUN   = 4,
    parameter int MASTER_RUN = 4,
    parameter int CW         = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  pclass_e           pclass,
    input  logic [CW-1:0]     idle_n,
    input  logic [CW-1:0]     quiet_n,
    input  logic [CW-1:0]     halt_n,
    input  logic [CW-1:0]     master_n,
    output lstate_e           state,
    output logic              change,
    output logic              sof,
    output logic [NUM_LS-1:0] set_vec
);

    lstate_e nxt;
    logic    chg_d;

    always_comb begin
        nxt = state;
        if (pclass == PC_JK)
            nxt = LS_ACTIVE;
        else if (idle_n >= CW'(SUPER_RUN))
            nxt = LS_SUPER;
        else if (idle_n >= CW'(IDLE_RUN))
            nxt = LS_IDLE;
        else if (master_n >= CW'(MASTER_RUN))
            nxt = LS_MASTER;
        else if (halt_n >= CW'(HALT_RUN))
            nxt = LS_HALT;
        else if (quiet_n >= CW'(QUIET_RUN))
            nxt = LS_QUIET;
        chg_d = (nxt != state);
    end

    for (genvar i = 0; i < NUM_LS; i++) begin : g_set
        assign set_vec[i] = chg_d && (nxt == lstate_e'(3'(i + 1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= LS_NONE;
            change <= 1'b0;
            sof    <= 1'b0;
        end else begin
            state  <= nxt;
            change <= chg_d;
            sof    <= (pclass == PC_JK) && (state == LS_ACTIVE);
        end
    end

    // R6: a frame start is reported only from the Active state
    assert_sof_active_R6: assert property (@(posedge clk) disable iff (rst)
        sof |-> ($past(state) == LS_ACTIVE && state == LS_ACTIVE));

    // R7: the change pulse coincides with a new code
    assert_change_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        change |-> (state != $past(state)));

    // R5: without a change pulse the code is held
    assert_state_held_R5: assert property (@(posedge clk) disable iff (rst)
        !change |-> $stable(state));

endmodule

// File: rtl/lsd_history.sv
module lsd_history
    import lsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_LS-1:0] set_vec,
    input  logic [NUM_LS-1:0] clr_vec,
    output logic [NUM_LS-1:0] hist
);

    for (genvar i = 0; i < NUM_LS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) hist[i] <= 1'b0;
            else     hist[i] <= (hist[i] & ~clr_vec[i]) | set_vec[i];
        end

        // R8: a set on the same cycle as a clear leaves the bit set
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(set_vec[i])) |-> hist[i]);

        // R8: a set bit survives until its own clear
        assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(hist[i]) && !$past(clr_vec[i])) |-> hist[i]);
    end

endmodule

// File: rtl/line_state_detector.sv
module line_state_detector
    import lsd_pkg::*;
#(
    parameter int IDLE_RUN   = 4,
    parameter int SUPER_RUN  = 8,
    parameter int QUIET_RUN  = 4,
    parameter int HALT_RUN   = 4,
    parameter int MASTER_RUN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SYM_W-1:0]  sym_hi,
    input  logic [SYM_W-1:0]  sym_lo,
    input  logic              frame_hold,
    input  logic [NUM_LS-1:0] hist_clr,
    output logic [2:0]        ls_code,
    output logic              ls_change,
    output logic              frame_start,
    output logic              align_phase,
    output logic [NUM_LS-1:0] ls_hist
);

    localparam int NRUN  = 4;
    localparam int R_IDL = 0;
    localparam int R_QUI = 1;
    localparam int R_HLT = 2;
    localparam int R_MST = 3;
    localparam int MAX_A = (SUPER_RUN > QUIET_RUN) ? SUPER_RUN : QUIET_RUN;
    localparam int MAX_B = (HALT_RUN > MASTER_RUN) ? HALT_RUN : MASTER_RUN;
    localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_L + 1);

    function automatic int run_limit(int idx);
        case (idx)
            R_IDL:   return SUPER_RUN;
            R_QUI:   return QUIET_RUN;
            R_HLT:   return HALT_RUN;
            default: return MASTER_RUN;
        endcase
    endfunction

    pair_t             pair;
    pclass_e           pclass;
    logic [1:0]        last_hq;
    logic [NRUN-1:0]   cont;
    logic [NRUN-1:0]   start;
    logic [CW-1:0]     cnt_next [NRUN];
    logic [CW-1:0]     cnt_q    [NRUN];
    lstate_e           state;
    logic [NUM_LS-1:0] set_vec;

    lsd_aligner u_align (
        .clk    (clk),
        .rst    (rst),
        .sym_hi (sym_hi),
        .sym_lo (sym_lo),
        .hold   (frame_hold),
        .pair   (pair),
        .phase  (align_phase)
    );

    assign pclass = classify(pair);

    // last_hq[0]: previous pair was Quiet, last_hq[1]: previous pair was Halt
    always_ff @(posedge clk) begin
        if (rst) last_hq <= '0;
        else     last_hq <= {pclass == PC_HALT, pclass == PC_QUIET};
    end

    always_comb begin
        cont[R_IDL]  = (pclass == PC_IDLE);
        cont[R_QUI]  = (pclass == PC_QUIET);
        cont[R_HLT]  = (pclass == PC_HALT);
        cont[R_MST]  = ((pclass == PC_QUIET) && last_hq[1]) ||
                       ((pclass == PC_HALT)  && last_hq[0]);
        start        = '0;
        start[R_MST] = (pclass == PC_QUIET) || (pclass == PC_HALT);
    end

    for (genvar g = 0; g < NRUN; g++) begin : g_run
        lsd_run_ctr #(
            .LIMIT (run_limit(g)),
            .W     (CW)
        ) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .cont     (cont[g]),
            .start    (start[g]),
            .cnt_next (cnt_next[g]),
            .cnt_q    (cnt_q[g])
        );
    end

    lsd_fsm #(
        .IDLE_RUN   (IDLE_RUN),
        .SUPER_RUN  (SUPER_RUN),
        .QUIET_RUN  (QUIET_RUN),
        .HALT_RUN   (HALT_RUN),
        .MASTER_RUN (MASTER_RUN),
        .CW         (CW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pclass   (pclass),
        .idle_n   (cnt_next[R_IDL]),
        .quiet_n  (cnt_next[R_QUI]),
        .halt_n   (cnt_next[R_HLT]),
        .master_n (cnt_next[R_MST]),
        .state    (state),
        .change   (ls_change),
        .sof      (frame_start),
        .set_vec  (set_vec)
    );

    lsd_history u_hist (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (hist_clr),
        .hist    (ls_hist)
    );

    assign ls_code = state;

    // R2: Super Idle is entered only once the Idle run has reached its full length
    assert_super_run_R2: assert property (@(posedge clk) disable iff (rst)
        (state == LS_SUPER && $past(state) != LS_SUPER) |-> (cnt_q[R_IDL] == CW'(SUPER_RUN)));

    // R7: a change of state always leaves the matching history bit set
    assert_hist_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (ls_change && state != LS_NONE) |-> ls_hist[ls_code - 3'd1]);

endmodule

// File: tb/test_line_state_detector.sv
module test_line_state_detector;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 33;

    localparam logic [9:0] P_I  = 10'b11111_11111;
    localparam logic [9:0] P_Q  = 10'b00000_00000;
    localparam logic [9:0] P_H  = 10'b00100_00100;
    localparam logic [9:0] P_JK = 10'b11000_10001;
    localparam logic [9:0] P_D  = 10'b01010_01011;

    // {pair[9:0], clr[5:0], code[2:0], hist[5:0], chg, sof}
    localparam logic [26:0] VEC [NV] = '{
        {P_I,  6'h00, 3'd0, 6'h00, 1'b0, 1'b0},  // 0
        {P_I,  6'h00, 3'd0, 6'h00, 1'b0, 1'b0},
        {P_I,  6'h00, 3'd0, 6'h00, 1'b0, 1'b0},
        {P_I,  6'h00, 3'd4, 6'h08, 1'b1, 1'b0},  // 3: Idle after 4 pairs
        {P_I,  6'h00, 3'd4, 6'h08, 1'b0, 1'b0},
        {P_I,  6'h00, 3'd4, 6'h08, 1'b0, 1'b0},
        {P_I,  6'h00, 3'd4, 6'h08, 1'b0, 1'b0},  // 6: 7 pairs, still Idle
        {P_I,  6'h00, 3'd5, 6'h18, 1'b1, 1'b0},  // 7: 8 pairs, Super Idle
        {P_I,  6'h00, 3'd5, 6'h18, 1'b0, 1'b0},  // 8: 9 pairs
        {P_JK, 6'h00, 3'd6, 6'h38, 1'b1, 1'b0},  // 9: J-K outside Active
        {P_D,  6'h00, 3'd6, 6'h38, 1'b0, 1'b0},
        {P_JK, 6'h00, 3'd6, 6'h38, 1'b0, 1'b1},  // 11: J-K inside Active
        {P_D,  6'h00, 3'd6, 6'h38, 1'b0, 1'b0},
        {P_Q,  6'h00, 3'd6, 6'h38, 1'b0, 1'b0},
        {P_Q,  6'h00, 3'd6, 6'h38, 1'b0, 1'b0},
        {P_Q,  6'h00, 3'd6, 6'h38, 1'b0, 1'b0},
        {P_Q,  6'h00, 3'd1, 6'h39, 1'b1, 1'b0},  // 16: Quiet
        {P_H,  6'h00, 3'd1, 6'h39, 1'b0, 1'b0},
        {P_Q,  6'h00, 3'd1, 6'h39, 1'b0, 1'b0},
        {P_H,  6'h00, 3'd3, 6'h3D, 1'b1, 1'b0},  // 19: Master
        {P_H,  6'h00, 3'd3, 6'h3D, 1'b0, 1'b0},
        {P_H,  6'h00, 3'd3, 6'h3D, 1'b0, 1'b0},
        {P_H,  6'h00, 3'd2, 6'h3F, 1'b1, 1'b0},  // 22: Halt
        {P_D,  6'h3F, 3'd2, 6'h00, 1'b0, 1'b0},  // 23: clear all, state held
        {P_I,  6'h00, 3'd2, 6'h00, 1'b0, 1'b0},
        {P_I,  6'h00, 3'd2, 6'h00, 1'b0, 1'b0},
        {P_I,  6'h00, 3'd2, 6'h00, 1'b0, 1'b0},
        {P_I,  6'h00, 3'd4, 6'h08, 1'b1, 1'b0},  // 27
        {P_D,  6'h00, 3'd4, 6'h08, 1'b0, 1'b0},
        {P_Q,  6'h00, 3'd4, 6'h08, 1'b0, 1'b0},
        {P_Q,  6'h00, 3'd4, 6'h08, 1'b0, 1'b0},
        {P_Q,  6'h00, 3'd4, 6'h08, 1'b0, 1'b0},
        {P_Q,  6'h09, 3'd1, 6'h01, 1'b1, 1'b0}   // 32: set beats clear
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] sym_hi, sym_lo;
    logic       frame_hold;
    logic [5:0] hist_clr;
    logic [2:0] ls_code;
    logic       ls_change, frame_start, align_phase;
    logic [5:0] ls_hist;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    line_state_detector i_line_state_detector (
        .clk         (clk),
        .rst         (rst),
        .sym_hi      (sym_hi),
        .sym_lo      (sym_lo),
        .frame_hold  (frame_hold),
        .hist_clr    (hist_clr),
        .ls_code     (ls_code),
        .ls_change   (ls_change),
        .frame_start (frame_start),
        .align_phase (align_phase),
        .ls_hist     (ls_hist)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] h, input logic [4:0] l,
                        input logic hd, input logic [5:0] c);
        @(negedge clk);
        sym_hi     = h;
        sym_lo     = l;
        frame_hold = hd;
        hist_clr   = c;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sym_hi = '0; sym_lo = '0; frame_hold = 1'b0; hist_clr = '0;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R11 reset ls_code",     ls_code,     0);
        chk("R11 reset ls_hist",     ls_hist,     0);
        chk("R11 reset ls_change",   ls_change,   0);
        chk("R11 reset frame_start", frame_start, 0);
        chk("R11 reset align_phase", align_phase, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic string req_of(int i);
        if (i <= 6)  return "R1 code";
        if (i <= 8)  return "R2 code";
        if (i <= 12) return "R6 code";
        if (i <= 22) return "R3 R4 code";
        if (i <= 28) return "R5 code";
        return "R3 code";
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][26:22], VEC[i][21:17], 1'b0, VEC[i][16:11]);
            chk($sformatf("%s vec %0d", req_of(i), i), ls_code,     VEC[i][10:8]);
            chk($sformatf("R7 R8 hist vec %0d", i),    ls_hist,     VEC[i][7:2]);
            chk($sformatf("R7 change vec %0d", i),     ls_change,   VEC[i][1]);
            chk($sformatf("R6 frame_start vec %0d", i), frame_start, VEC[i][0]);
        end

        // R11: reset from a non-zero history
        do_reset();

        // R9: J in the low symbol, K in the next high symbol flips the pairing
        step(5'b11111, 5'b11000, 1'b0, 6'h00);
        chk("R9 before straddle code", ls_code, 0);
        step(5'b10001, 5'b01011, 1'b0, 6'h00);
        chk("R9 straddle phase",  align_phase, 1);
        chk("R9 straddle code",   ls_code,     6);
        chk("R9 straddle change", ls_change,   1);
        step(5'b11111, 5'b11111, 1'b0, 6'h00);
        for (int k = 0; k < 3; k++) begin
            step(5'b11111, 5'b11111, 1'b0, 6'h00);
            chk("R9 shifted idle run", ls_code, 6);
        end
        step(5'b11111, 5'b11111, 1'b0, 6'h00);
        chk("R9 shifted idle declared", ls_code,     4);
        chk("R9 phase kept",            align_phase, 1);

        // R10: the same straddle under hold does nothing
        do_reset();
        step(5'b11111, 5'b11000, 1'b1, 6'h00);
        step(5'b10001, 5'b01011, 1'b1, 6'h00);
        chk("R10 hold phase",  align_phase, 0);
        chk("R10 hold code",   ls_code,     0);
        chk("R10 hold change", ls_change,   0);
        step(5'b01010, 5'b01011, 1'b0, 6'h00);
        chk("R10 after hold phase", align_phase, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule